// File: doc/BRIEF.md
# Four-Lane Element Shuffle Unit

This block rearranges 32-bit elements of two 128-bit operands. Each operand is viewed as four elements, element k occupying bits [32k+31:32k]. In shuffle mode an 8-bit immediate carries four 2-bit lane indices. The two lower result elements are picked from the destination operand and the two upper result elements are picked from the source operand. Feeding the same value on both operands turns the shuffle into a general permute or broadcast of one vector.

A second mode copies the upper half of the source into the lower half of the result and keeps the upper half of the destination. The result is registered: a request presented with `in_valid` appears on `out_data` one clock later, flagged by `out_valid`. Element bit patterns are moved and never modified.

Top module: `lane_permute_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` equals the `in_valid` value sampled at the previous rising edge (one cycle latency).
- R3: With `in_op` = 0 (shuffle), result element 0 is destination element `in_imm[1:0]` and result element 1 is destination element `in_imm[3:2]`, bit for bit.
- R4: With `in_op` = 0, result element 2 is source element `in_imm[5:4]` and result element 3 is source element `in_imm[7:6]`.
- R5: With `in_op` = 1 (half move), `out_data[63:0]` takes `in_src[127:64]` and `out_data[127:64]` takes `in_dst[127:64]`; the immediate has no effect on the result.
- R6: When `in_valid` is low at a rising edge, `out_data` keeps its previous value whatever the other inputs carry.
- R7: In shuffle mode an immediate of 0x55 gives destination element 1 in result elements 0 and 1 and source element 1 in result elements 2 and 3.
- R8: With both operands equal to a vector a, the immediate 0xC9 (indices 3,0,2,1 from the top field down) gives a[1], a[2], a[0], a[3] from result element 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 1 | 0 = shuffle, 1 = half move |
| in_imm | input | 8 | Four 2-bit lane indices, element 0 index in bits [1:0] |
| in_dst | input | 128 | Destination operand |
| in_src | input | 128 | Source operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 128 | Registered result |

## Verification
The two functions that meet in one cycle are the presentation of a finished result and the capture of the next request, possibly of the other mode. The bench provokes this with unbroken runs of valid requests that alternate between shuffle and half move, with new operands and immediates every cycle, and with idle gaps whose inputs still toggle. A behavioural model predicts the registered output and strobe for each clock, and every cycle is compared after the edge, so a result corrupted by the following request or by the other mode's path shows up at once.

// File: rtl/lperm_pkg.sv
package lperm_pkg;
    localparam int LANE_W     = 32;
    localparam int LANES      = 4;
    localparam int SEL_W      = $clog2(LANES);
    localparam int IMM_W      = LANES * SEL_W;
    localparam int VEC_W      = LANE_W * LANES;
    localparam int HALF_LANES = LANES / 2;
    localparam int HALF_W     = VEC_W / 2;

    typedef enum logic {
        OP_SHUF = 1'b0,
        OP_HMOV = 1'b1
    } op_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] data;
    } res_t;

    // Element extraction used by the properties, separate from the mux tree
    function automatic logic [LANE_W-1:0] elem_at(input logic [VEC_W-1:0] v,
                                                  input logic [SEL_W-1:0] idx);
        return v[idx*LANE_W +: LANE_W];
    endfunction
endpackage

// File: rtl/lperm_lane_mux.sv
module lperm_lane_mux #(
    parameter int LANE_W = lperm_pkg::LANE_W,
    parameter int LANES  = lperm_pkg::LANES,
    localparam int SEL_W = $clog2(LANES),
    localparam int VEC_W = LANE_W * LANES
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic [SEL_W-1:0]  sel,
    output logic [LANE_W-1:0] lane
);
    always_comb begin
        lane = '0;
        for (int k = 0; k < LANES; k++) begin
            if (sel == SEL_W'(k)) begin
                lane = vec[k*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/lperm_hmove.sv
module lperm_hmove #(
    parameter int VEC_W   = lperm_pkg::VEC_W,
    localparam int HALF_W = VEC_W / 2
) (
    input  logic [VEC_W-1:0] dst,
    input  logic [VEC_W-1:0] src,
    output logic [VEC_W-1:0] res
);
    // upper half of destination kept, upper half of source dropped low
    assign res = {dst[VEC_W-1:HALF_W], src[VEC_W-1:HALF_W]};
endmodule

// File: rtl/lperm_stage.sv
module lperm_stage
    import lperm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             nxt_valid,
    input  logic [VEC_W-1:0] nxt_data,
    output res_t             held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            held.valid <= nxt_valid;
            if (nxt_valid) begin
                held.data <= nxt_data;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!held.valid && held.data == '0)); // R1
    AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
        nxt_valid |=> held.valid); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !nxt_valid |=> !held.valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !nxt_valid |=> $stable(held.data)); // R6
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
    import lperm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [VEC_W-1:0] in_dst,
    input  logic [VEC_W-1:0] in_src,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);
    op_e              op;
    logic [VEC_W-1:0] shuf_vec;
    logic [VEC_W-1:0] hmov_vec;
    logic [VEC_W-1:0] nxt_vec;
    res_t             held;

    assign op = op_e'(in_op);

    // Low result lanes draw on the destination, high lanes on the source
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k < HALF_LANES) begin : g_from_dst
            lperm_lane_mux #(.LANE_W(LANE_W), .LANES(LANES)) i_mux (
                .vec  (in_dst),
                .sel  (in_imm[k*SEL_W +: SEL_W]),
                .lane (shuf_vec[k*LANE_W +: LANE_W])
            );
        end else begin : g_from_src
            lperm_lane_mux #(.LANE_W(LANE_W), .LANES(LANES)) i_mux (
                .vec  (in_src),
                .sel  (in_imm[k*SEL_W +: SEL_W]),
                .lane (shuf_vec[k*LANE_W +: LANE_W])
            );
        end
    end

    lperm_hmove #(.VEC_W(VEC_W)) i_hmove (
        .dst (in_dst),
        .src (in_src),
        .res (hmov_vec)
    );

    assign nxt_vec = (op == OP_HMOV) ? hmov_vec : shuf_vec;

    lperm_stage i_stage (
        .clk       (clk),
        .rst       (rst),
        .nxt_valid (in_valid),
        .nxt_data  (nxt_vec),
        .held      (held)
    );

    assign out_valid = held.valid;
    assign out_data  = held.data;

    AST_LOW_LANE0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 1'b0) |=>
        out_data[LANE_W-1:0] == $past(elem_at(in_dst, in_imm[SEL_W-1:0]))); // R3
    AST_LOW_LANE1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 1'b0) |=>
        out_data[LANE_W +: LANE_W] == $past(elem_at(in_dst, in_imm[SEL_W +: SEL_W]))); // R3
    AST_HIGH_LANE_TOP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 1'b0) |=>
        out_data[VEC_W-1 -: LANE_W] == $past(elem_at(in_src, in_imm[IMM_W-1 -: SEL_W]))); // R4
    AST_HALF_MOVE_LOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 1'b1) |=>
        out_data[HALF_W-1:0] == $past(in_src[VEC_W-1:HALF_W])); // R5
    AST_HALF_MOVE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 1'b1) |=>
        out_data[VEC_W-1:HALF_W] == $past(in_dst[VEC_W-1:HALF_W])); // R5
    AST_BCAST_PAIRS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 1'b0 && in_imm == IMM_W'(8'h55)) |=>
        (out_data[LANE_W-1:0] == out_data[LANE_W +: LANE_W] &&
         out_data[VEC_W-1 -: LANE_W] == out_data[VEC_W-1-LANE_W -: LANE_W])); // R7
endmodule

// File: tb/test_lane_permute_unit.sv
`timescale 1ns/1ps
module test_lane_permute_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_op = 1'b0;
    logic [7:0]   in_imm = '0;
    logic [127:0] in_dst = '0;
    logic [127:0] in_src = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    armed    = 1'b0;
    bit    done     = 1'b0;
    string cur_tag  = "R3";
    string exp_tag  = "R1";
    bit           exp_v = 1'b0;
    logic [127:0] exp_d = '0;

    always #10 clk = ~clk;

    lane_permute_unit i_lane_permute_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_imm(in_imm), .in_dst(in_dst), .in_src(in_src),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [127:0] model(bit op, logic [7:0] imm,
                                           logic [127:0] d, logic [127:0] s);
        logic [127:0] r;
        if (op) begin
            r[63:0]   = s[127:64];
            r[127:64] = d[127:64];
        end else begin
            for (int e = 0; e < 4; e++) begin
                int idx;
                idx = int'(imm[2*e +: 2]);
                if (e < 2) r[32*e +: 32] = d[32*idx +: 32];
                else       r[32*e +: 32] = s[32*idx +: 32];
            end
        end
        return r;
    endfunction

    // Reference: what the outputs must show after this rising edge
    always @(posedge clk) begin
        if (rst) begin
            exp_v   = 1'b0;
            exp_d   = '0;
            exp_tag = "R1";
        end else begin
            exp_v = in_valid;
            if (in_valid) begin
                exp_d   = model(in_op, in_imm, in_dst, in_src);
                exp_tag = cur_tag;
            end else begin
                exp_tag = "R6";
            end
        end
        armed = 1'b1;
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            n_checks++;
            if (out_valid !== exp_v) begin
                n_fails++;
                $display("FAIL R2 (%s) out_valid actual=%b expected=%b", exp_tag, out_valid, exp_v);
            end
            n_checks++;
            if (out_data !== exp_d) begin
                n_fails++;
                $display("FAIL %s out_data actual=%h expected=%h", exp_tag, out_data, exp_d);
            end
        end
    end

    task automatic issue(bit op, logic [7:0] imm, logic [127:0] d, logic [127:0] s, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_imm = imm; in_dst = d; in_src = s; cur_tag = tag;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_op    = 1'(i);
            in_imm   = 8'($urandom);
            in_dst   = {$urandom, $urandom, $urandom, $urandom};
            in_src   = {$urandom, $urandom, $urandom, $urandom};
        end
    endtask

    function automatic logic [127:0] rvec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    localparam logic [127:0] VA = 128'hA3A3A3A3_A2A2A2A2_A1A1A1A1_A0A0A0A0;
    localparam logic [127:0] VB = 128'hB3B3B3B3_B2B2B2B2_B1B1B1B1_B0B0B0B0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;                                    // R1 checked during reset cycles
        issue(1'b0, 8'hE4, VA, VB, "R3");              // identity order
        issue(1'b0, 8'h1B, VA, VB, "R4");              // reversed indices
        issue(1'b0, 8'h55, VA, VB, "R7");              // broadcast element 1
        issue(1'b0, 8'hC9, VA, VA, "R8");              // expect a1,a2,a0,a3
        issue(1'b1, 8'h00, VA, VB, "R5");
        issue(1'b1, 8'hFF, VA, VB, "R5");              // immediate must not matter
        idle(3);                                       // R6 with toggling inputs
        for (int i = 0; i < 40; i++)                   // back-to-back alternating modes
            issue(1'(i), 8'($urandom), rvec(), rvec(), (i % 2) ? "R5" : "R3");
        idle(2);
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(3) == 0) idle(1);
            else issue(1'($urandom), 8'($urandom), rvec(), rvec(), "R4");
        end
        for (int i = 0; i < 8; i++) begin             // same operand permutes
            logic [127:0] v;
            v = rvec();
            issue(1'b0, 8'($urandom), v, v, "R8");
        end
        @(negedge clk);
        in_valid = 1'b1; rst = 1'b1;                   // R1 mid-run reset with valid held
        repeat (2) @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        idle(2);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #4000000;
        n_checks++;
        n_fails++;
        done = 1'b1;
        $display("FAIL watchdog expired: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule